// File: doc/BRIEF.md
# Double-Banked Configuration Switcher

This block keeps the settings of a processing datapath in two register banks. The active bank drives the datapath outputs without interruption. The shadow bank is the one a control processor writes through a simple register write port, and it can do so while the datapath is still working through its current run. When the datapath reports that its run has finished and the controller has marked the shadow bank ready, the shadow contents move into the active bank on one clock edge. A start pulse then tells the datapath to begin with the new settings. Reconfiguration therefore overlaps processing instead of stalling it.

A task is a fixed sequence of configuration identifiers. The block holds the identifier that the next swap will install. After each swap that identifier advances by one, wrapping at the sequence length, and the controller can also overwrite it. If the datapath finishes before the shadow bank is ready, the block records a waiting state and performs the swap as soon as the bank is committed. After each swap an event flag tells the controller to prepare the following configuration. The active identifier, the queued identifier and the flags are visible on a status word.

Write address map (WORDS = number of configuration words): addresses 0..WORDS-1 write shadow words, WORDS commits the shadow bank, WORDS+1 loads the queued identifier from the low bits of the data, WORDS+2 clears the event flag, and any higher address is ignored.

Top module: `cfg_bank_switcher`

## Requirements
- R1: After reset the active words and start are 0. The status word, packed as {queued id, active id, waiting, event, shadow valid} from MSB to LSB, reads queued id 0, active id 0, waiting 1, event 0 and valid 0.
- R2: Writes to shadow words (addresses 0..WORDS-1) never change the active outputs until a swap occurs.
- R3: A write to address WORDS sets shadow valid. A swap happens on the edge at which run_done is high (or a completed run is waiting) while shadow valid is set. On the following cycle the active outputs equal the shadow words sampled at that edge, and start is high for exactly that one cycle.
- R4: If run_done is high while shadow valid is clear, waiting is set and no swap occurs. The swap then happens on the first edge at which shadow valid is set, and waiting clears.
- R5: A swap clears shadow valid and sets the event flag. A write to address WORDS+2 clears the event flag. An event-clear write in the same cycle as a swap has no effect, so the flag stays set.
- R6: At a swap the active id takes the queued id, and the queued id advances by one, wrapping from SEQ_LEN-1 to 0.
- R7: A write (shadow word, commit or queued-id load) presented in a swap cycle is not lost and does not reach the active bank. It takes effect one cycle later, and a new write in that later cycle is applied as well.
- R8: A write to address WORDS+1 sets the queued id to the low ID_W bits of the data.
- R9: A write to an address above WORDS+2 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | WORD_W | Register write data |
| run_done | input | 1 | Datapath finished its current run |
| act_cfg | output | WORDS*WORD_W | Active configuration words, word w at bits w*WORD_W upward |
| cfg_start | output | 1 | One-cycle pulse when new active settings apply |
| status | output | 2*ID_W+3 | {queued id, active id, waiting, event, shadow valid} |

## Verification
On every cycle, the assertions check the following: the active bank and the active id stay frozen outside swaps, each swap copies exactly the sampled shadow words and queued id, and each swap clears valid and waiting while raising the event flag and start. They also check that a deferred write is never pending when a swap occurs, and that a finished run seen without a valid shadow bank turns into a waiting state. Only the bench scenarios can show the full ordered sequence and its wrap. They also show that a write made during a swap cycle lands in the next configuration and not the current one, that a held commit arms the bank one cycle late, that an event clear coinciding with a swap is lost, and that unmapped addresses leave the status intact.

// File: rtl/cfgsw_pkg.sv
package cfgsw_pkg;

  typedef enum logic [2:0] {
    ROLE_WORD,
    ROLE_COMMIT,
    ROLE_NEXT,
    ROLE_ACK,
    ROLE_NONE
  } wr_role_e;

  // Map a write address onto its role: configuration words first,
  // then the three control addresses, anything beyond is unused.
  function automatic wr_role_e decode_role(input int unsigned addr,
                                           input int unsigned words);
    if (addr < words)          return ROLE_WORD;
    else if (addr == words)    return ROLE_COMMIT;
    else if (addr == words + 1) return ROLE_NEXT;
    else if (addr == words + 2) return ROLE_ACK;
    else                       return ROLE_NONE;
  endfunction

endpackage

// File: rtl/cfgsw_shadow_port.sv
module cfgsw_shadow_port
  import cfgsw_pkg::*;
#(
  parameter int unsigned WORDS  = 4,
  parameter int unsigned WORD_W = 8,
  parameter int unsigned ID_W   = 3,
  parameter int unsigned AW     = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [WORD_W-1:0]       wr_data,
  input  logic                    swap,
  output logic [WORDS*WORD_W-1:0] shadow_flat,
  output logic                    commit,
  output logic                    next_wr,
  output logic [ID_W-1:0]         next_val,
  output logic                    ack
);

  logic              live_en;
  logic              hold_set;
  wr_role_e          live_role;
  wr_role_e          held_role;
  logic              held_q;
  logic [AW-1:0]     held_addr_q;
  logic [WORD_W-1:0] held_data_q;

  assign live_en   = wr_en & ~swap;
  assign hold_set  = wr_en & swap;
  assign live_role = decode_role(32'(wr_addr), WORDS);
  assign held_role = decode_role(32'(held_addr_q), WORDS);

  // Control-side effects; the event clear is never deferred.
  always_comb begin
    commit   = (live_en && live_role == ROLE_COMMIT) ||
               (held_q && held_role == ROLE_COMMIT);
    next_wr  = (live_en && live_role == ROLE_NEXT) ||
               (held_q && held_role == ROLE_NEXT);
    next_val = (live_en && live_role == ROLE_NEXT) ? wr_data[ID_W-1:0]
                                                   : held_data_q[ID_W-1:0];
    ack      = wr_en && live_role == ROLE_ACK;
  end

  // One-entry deferral slot for writes arriving in a swap cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q      <= 1'b0;
      held_addr_q <= '0;
      held_data_q <= '0;
    end else begin
      held_q <= hold_set;
      if (hold_set) begin
        held_addr_q <= wr_addr;
        held_data_q <= wr_data;
      end
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] word_d;
    logic              word_en;

    always_comb begin
      word_d  = word_q;
      word_en = 1'b0;
      if (held_q && held_role == ROLE_WORD && held_addr_q == AW'(w)) begin
        word_d  = held_data_q;
        word_en = 1'b1;
      end
      if (live_en && live_role == ROLE_WORD && wr_addr == AW'(w)) begin
        word_d  = wr_data;
        word_en = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q <= '0;
      else if (word_en) word_q <= word_d;
    end

    assign shadow_flat[w*WORD_W +: WORD_W] = word_q;
  end

  // R7: a deferred write is always drained before another swap can occur.
  assert_held_not_in_swap_R7: assert property (
    @(posedge clk) disable iff (!rst_n) held_q |-> !swap);

  // R7: a write colliding with a swap is captured for the next cycle.
  assert_collision_held_R7: assert property (
    @(posedge clk) disable iff (!rst_n) (wr_en && swap) |=> held_q);

endmodule

// File: rtl/cfgsw_seq_ctrl.sv
module cfgsw_seq_ctrl #(
  parameter int unsigned ID_W    = 3,
  parameter int unsigned SEQ_LEN = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_done,
  input  logic            commit,
  input  logic            next_wr,
  input  logic [ID_W-1:0] next_val,
  input  logic            ack,
  output logic            swap,
  output logic            valid_q,
  output logic            pending_q,
  output logic            evt_q,
  output logic            start_q,
  output logic [ID_W-1:0] act_id_q,
  output logic [ID_W-1:0] nxt_q
);

  localparam logic [ID_W-1:0] LAST_ID = ID_W'(SEQ_LEN - 1);

  logic            valid_d;
  logic            pending_d;
  logic            evt_d;
  logic [ID_W-1:0] act_id_d;
  logic [ID_W-1:0] nxt_d;

  assign swap = (run_done | pending_q) & valid_q;

  always_comb begin
    valid_d   = valid_q;
    pending_d = pending_q;
    evt_d     = evt_q;
    act_id_d  = act_id_q;
    nxt_d     = nxt_q;
    if (swap) begin
      valid_d   = 1'b0;
      pending_d = 1'b0;
      evt_d     = 1'b1;
      act_id_d  = nxt_q;
      nxt_d     = (nxt_q == LAST_ID) ? '0 : nxt_q + ID_W'(1);
    end else begin
      if (commit)              valid_d   = 1'b1;
      if (run_done && !valid_q) pending_d = 1'b1;
      if (ack)                 evt_d     = 1'b0;
      if (next_wr)             nxt_d     = next_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      pending_q <= 1'b1;
      evt_q     <= 1'b0;
      start_q   <= 1'b0;
      act_id_q  <= '0;
      nxt_q     <= '0;
    end else begin
      valid_q   <= valid_d;
      pending_q <= pending_d;
      evt_q     <= evt_d;
      start_q   <= swap;
      act_id_q  <= act_id_d;
      nxt_q     <= nxt_d;
    end
  end

  // R3/R5: a swap consumes the shadow bank and announces itself.
  assert_swap_effects_R5: assert property (
    @(posedge clk) disable iff (!rst_n)
    swap |=> (!valid_q && evt_q && start_q && !pending_q));

  // R6: the active id moves only at a swap, and then to the queued id.
  assert_id_frozen_R6: assert property (
    @(posedge clk) disable iff (!rst_n) !swap |=> $stable(act_id_q));

  assert_id_loaded_R6: assert property (
    @(posedge clk) disable iff (!rst_n) swap |=> act_id_q == $past(nxt_q));

  // R4: a finished run without a ready bank turns into waiting.
  assert_wait_recorded_R4: assert property (
    @(posedge clk) disable iff (!rst_n)
    (run_done && !valid_q) |=> pending_q);

endmodule

// File: rtl/cfgsw_active_bank.sv
module cfgsw_active_bank #(
  parameter int unsigned WORDS  = 4,
  parameter int unsigned WORD_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    swap,
  input  logic [WORDS*WORD_W-1:0] shadow_flat,
  output logic [WORDS*WORD_W-1:0] act_q
);

  logic [WORDS*WORD_W-1:0] act_d;

  always_comb begin
    act_d = act_q;
    if (swap) act_d = shadow_flat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    act_q <= '0;
    else if (swap) act_q <= act_d;
  end

  // R2: active settings hold outside a swap.
  assert_active_frozen_R2: assert property (
    @(posedge clk) disable iff (!rst_n) !swap |=> $stable(act_q));

  // R3: a swap copies the shadow words seen at that edge.
  assert_active_copy_R3: assert property (
    @(posedge clk) disable iff (!rst_n) swap |=> act_q == $past(shadow_flat));

endmodule

// File: rtl/cfg_bank_switcher.sv
module cfg_bank_switcher #(
  parameter int unsigned WORDS   = 4,
  parameter int unsigned WORD_W  = 8,
  parameter int unsigned SEQ_LEN = 5,
  localparam int unsigned ID_W   = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1,
  localparam int unsigned AW     = $clog2(WORDS + 3),
  localparam int unsigned STAT_W = 2 * ID_W + 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [WORD_W-1:0]       wr_data,
  input  logic                    run_done,
  output logic [WORDS*WORD_W-1:0] act_cfg,
  output logic                    cfg_start,
  output logic [STAT_W-1:0]       status
);

  logic                    swap;
  logic [WORDS*WORD_W-1:0] shadow_flat;
  logic                    commit;
  logic                    next_wr;
  logic [ID_W-1:0]         next_val;
  logic                    ack;
  logic                    valid_q;
  logic                    pending_q;
  logic                    evt_q;
  logic [ID_W-1:0]         act_id_q;
  logic [ID_W-1:0]         nxt_q;

  cfgsw_shadow_port #(
    .WORDS(WORDS), .WORD_W(WORD_W), .ID_W(ID_W), .AW(AW)
  ) u_shadow (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .swap(swap), .shadow_flat(shadow_flat),
    .commit(commit), .next_wr(next_wr), .next_val(next_val), .ack(ack)
  );

  cfgsw_seq_ctrl #(
    .ID_W(ID_W), .SEQ_LEN(SEQ_LEN)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .run_done(run_done), .commit(commit),
    .next_wr(next_wr), .next_val(next_val), .ack(ack), .swap(swap),
    .valid_q(valid_q), .pending_q(pending_q), .evt_q(evt_q),
    .start_q(cfg_start), .act_id_q(act_id_q), .nxt_q(nxt_q)
  );

  cfgsw_active_bank #(
    .WORDS(WORDS), .WORD_W(WORD_W)
  ) u_active (
    .clk(clk), .rst_n(rst_n), .swap(swap), .shadow_flat(shadow_flat),
    .act_q(act_cfg)
  );

  assign status = {nxt_q, act_id_q, pending_q, evt_q, valid_q};

endmodule

// File: tb/cfg_bank_switcher_bench.sv
module cfg_bank_switcher_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WORDS   = 4;
  localparam int WORD_W  = 8;
  localparam int SEQ_LEN = 5;
  localparam int AW      = 3;
  localparam int STAT_W  = 9;
  localparam int A_COMMIT = WORDS;
  localparam int A_NEXT   = WORDS + 1;
  localparam int A_ACK    = WORDS + 2;

  logic                    clk;
  logic                    rst_n;
  logic                    wr_en;
  logic [AW-1:0]           wr_addr;
  logic [WORD_W-1:0]       wr_data;
  logic                    run_done;
  logic [WORDS*WORD_W-1:0] act_cfg;
  logic                    cfg_start;
  logic [STAT_W-1:0]       status;

  cfg_bank_switcher #(
    .WORDS(WORDS), .WORD_W(WORD_W), .SEQ_LEN(SEQ_LEN)
  ) u_cfg_bank_switcher (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .run_done(run_done), .act_cfg(act_cfg),
    .cfg_start(cfg_start), .status(status)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  logic [WORD_W-1:0] m_sh [WORDS];
  logic [WORD_W-1:0] m_act[WORDS];
  int m_act_id = 0;
  int m_nxt    = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_act(input string tag);
    logic [WORDS*WORD_W-1:0] e;
    for (int w = 0; w < WORDS; w++) e[w*WORD_W +: WORD_W] = m_act[w];
    chk(tag, 64'(act_cfg), 64'(e));
  endtask

  task automatic check_stat(input string tag, input logic v, input logic e, input logic wt);
    logic [STAT_W-1:0] x;
    x = {3'(m_nxt), 3'(m_act_id), wt, e, v};
    chk(tag, 64'(status), 64'(x));
  endtask

  task automatic wr(input int addr, input int data);
    wr_en   = 1'b1;
    wr_addr = AW'(addr);
    wr_data = WORD_W'(data);
    @(negedge clk);
    wr_en = 1'b0;
    if (addr < WORDS) m_sh[addr] = WORD_W'(data);
    if (addr == A_NEXT) m_nxt = data % 8;
  endtask

  task automatic model_swap();
    for (int w = 0; w < WORDS; w++) m_act[w] = m_sh[w];
    m_act_id = m_nxt;
    m_nxt = (m_nxt == SEQ_LEN - 1) ? 0 : m_nxt + 1;
  endtask

  task automatic pulse_done();
    run_done = 1'b1;
    @(negedge clk);
    run_done = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int w = 0; w < WORDS; w++) begin m_sh[w] = '0; m_act[w] = '0; end
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; run_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state and status layout
    check_stat("R1 status after reset", 1'b0, 1'b0, 1'b1);
    check_act("R1 active words after reset");
    chk("R1 start after reset", 64'(cfg_start), 64'd0);

    // Walk the whole sequence once
    for (int k = 0; k < SEQ_LEN; k++) begin
      bit waiting;
      waiting = (k == 0) || (k == 3);
      if (k == 3) begin
        pulse_done();
        check_stat("R4 done without valid bank waits", 1'b0, 1'b0, 1'b1);
        chk("R4 no start while waiting", 64'(cfg_start), 64'd0);
      end
      for (int w = 0; w < WORDS; w++) wr(w, k * 16 + w * 3 + 1);
      check_act("R2 shadow writes leave active alone");
      wr(A_COMMIT, 0);
      check_stat("R3 commit sets valid", 1'b1, 1'b0, waiting);
      chk("R3 no start before swap", 64'(cfg_start), 64'd0);
      if (waiting) begin
        @(negedge clk);
      end else begin
        check_act("R2 committed bank not yet active");
        pulse_done();
      end
      model_swap();
      chk("R3 start pulse at swap", 64'(cfg_start), 64'd1);
      check_act("R3 active takes shadow words");
      check_stat("R6 ids and flags after swap", 1'b0, 1'b1, 1'b0);
      wr(A_ACK, 0);
      check_stat("R5 event cleared by write", 1'b0, 1'b0, 1'b0);
      chk("R3 start lasts one cycle", 64'(cfg_start), 64'd0);
    end
    chk("R6 queued id wrapped to zero", 64'(status[8:6]), 64'd0);

    // R8: overwrite the queued id
    wr(A_NEXT, 2);
    check_stat("R8 queued id loaded", 1'b0, 1'b0, 1'b0);
    for (int w = 0; w < WORDS; w++) wr(w, 8'h60 + w);
    wr(A_COMMIT, 0);
    pulse_done();
    model_swap();
    check_stat("R8 loaded id becomes active", 1'b0, 1'b1, 1'b0);
    check_act("R8 words follow loaded id");
    wr(A_ACK, 0);

    // R7: shadow word write in a swap cycle is deferred
    for (int w = 0; w < WORDS; w++) wr(w, 8'hA0 + w);
    wr(A_COMMIT, 0);
    run_done = 1'b1; wr_en = 1'b1; wr_addr = AW'(0); wr_data = 8'h5C;
    @(negedge clk);
    model_swap();
    chk("R7 start on collision swap", 64'(cfg_start), 64'd1);
    check_act("R7 swap uses pre-write contents");
    run_done = 1'b0; wr_en = 1'b1; wr_addr = AW'(1); wr_data = 8'h3D;
    @(negedge clk);
    wr_en = 1'b0;
    m_sh[0] = 8'h5C; m_sh[1] = 8'h3D;
    check_stat("R7 status after collision", 1'b0, 1'b1, 1'b0);
    check_act("R7 deferred write kept out of active");
    wr(A_COMMIT, 0);
    pulse_done();
    model_swap();
    check_act("R7 deferred and following writes both landed");

    // R7: commit in a swap cycle arms the bank one cycle late
    wr(A_COMMIT, 0);
    run_done = 1'b1; wr_en = 1'b1; wr_addr = AW'(A_COMMIT); wr_data = '0;
    @(negedge clk);
    model_swap();
    run_done = 1'b0; wr_en = 1'b0;
    check_stat("R7 held commit not yet applied", 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    check_stat("R7 held commit applied", 1'b1, 1'b1, 1'b0);

    // R5: event clear coinciding with a swap is lost
    run_done = 1'b1; wr_en = 1'b1; wr_addr = AW'(A_ACK); wr_data = '0;
    @(negedge clk);
    model_swap();
    run_done = 1'b0; wr_en = 1'b0;
    check_stat("R5 event kept when clear meets swap", 1'b0, 1'b1, 1'b0);
    check_act("R5 swap still applied");

    // R9: unmapped address changes nothing
    wr(7, 8'hFF);
    check_stat("R9 unmapped write ignored", 1'b0, 1'b1, 1'b0);
    check_act("R9 active unchanged by unmapped write");
    wr(A_ACK, 0);
    check_stat("R5 event cleared at end", 1'b0, 1'b0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule